// File: doc/BRIEF.md
# Address-Translation Control Register Bank

This block holds the software-visible control state of an address-translation unit: a control word, the high and low halves of a page-table entry being loaded (the high half carries the 8-bit address-space identifier in its low byte), an entry assist field, the translation table base, the faulting address, and three event-code registers (trap code, exception event, interrupt event). The translation buffer lives elsewhere. This block only sends it two strobes: an invalidate-all request and a flush request.

Software reaches the bank through a simple request port that takes one access per cycle. The response comes back on the following cycle. Some writes have side effects. Setting the invalidate bit of the control word raises the invalidate strobe, and that bit is never stored. Loading an entry-high value whose address-space identifier differs from the one already held raises the flush strobe. The assist and event-code registers keep only their low bits.

Word offsets, in units of 4 bytes from zero: control, entry high, entry low, assist, table base, fault address, trap code, exception event, interrupt event.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every register reads as zero and neither strobe is high.
- R2: Only a size code of 2 (a 32-bit access) is accepted. Any other size gets an error response with zero read data and no strobe, and no register changes.
- R3: An offset with nonzero bits [1:0], or a word index of 9 or more, gets an error response with zero read data and no strobe, and no register changes.
- R4: A control write with the invalidate bit set (bit INVAL_BIT, default 2) raises `tlb_inval` for one cycle, in the cycle after the request. That bit always reads back as 0.
- R5: A control write with the invalidate bit clear raises no strobe and stores the other 31 bits as written.
- R6: An entry-high write raises `asid_flush` for one cycle, in the cycle after the request, only when written bits [7:0] differ from the stored bits [7:0]. The full 32-bit word is stored either way.
- R7: The assist register keeps written bits [3:0]; all higher bits read as zero.
- R8: The trap code, exception event and interrupt event registers each keep written bits [10:0]; all higher bits read as zero.
- R9: The entry-low, table base and fault address registers keep all 32 written bits.
- R10: Every accepted request gets `rsp_valid` exactly one cycle later. A read returns the stored value, including a value written in the previous cycle. A write returns zero data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_size | input | 2 | Access size code (log2 of bytes); 2 = 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| tlb_inval | output | 1 | One-cycle invalidate-all strobe |
| asid_flush | output | 1 | One-cycle flush strobe on identifier change |

## Verification
Write data is tried as all ones, as alternating patterns and as sparse values. All ones shows whether each register's keep-mask and the dropped invalidate bit are applied. The sparse values show whether kept bits land in the right positions. Entry-high writes alternate between a new identifier, the same identifier with different upper bits, and a change in the lowest bit alone. This separates a comparison of the identifier from a comparison of the whole word or of the wrong byte. Wrong sizes, misaligned offsets and unmapped indices are each sent with data that would otherwise fire a strobe, and every register is read back afterwards. Back-to-back invalidate writes and a read immediately after a write check the one-cycle response and strobe timing.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

    localparam int DW         = 32;
    localparam int ASID_W     = 8;
    localparam int NUM_REGS   = 9;
    localparam int ID_W       = $clog2(NUM_REGS);
    localparam int ASSIST_KEEP = 4;
    localparam int EVT_KEEP    = 11;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    // Word index of each register; the bank's address map depends on this order.
    typedef enum logic [ID_W-1:0] {
        RID_CTRL   = 4'd0,
        RID_PTEH   = 4'd1,
        RID_PTEL   = 4'd2,
        RID_ASSIST = 4'd3,
        RID_TBASE  = 4'd4,
        RID_FAULT  = 4'd5,
        RID_TRAP   = 4'd6,
        RID_EXC    = 4'd7,
        RID_INT    = 4'd8
    } reg_id_e;

    // A decoded access that passed size, alignment and range checks.
    typedef struct packed {
        logic           valid;
        logic           write;
        reg_id_e        id;
        logic [DW-1:0]  wdata;
    } acc_t;

    // Bits each register retains from a write.
    function automatic logic [DW-1:0] keep_mask(reg_id_e id, int unsigned inval_bit);
        logic [DW-1:0] m;
        case (id)
            RID_CTRL:                  m = ~(DW'(1) << inval_bit);
            RID_ASSIST:                m = {DW{1'b1}} >> (DW - ASSIST_KEEP);
            RID_TRAP, RID_EXC, RID_INT: m = {DW{1'b1}} >> (DW - EVT_KEEP);
            default:                   m = {DW{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
    import mmu_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    output acc_t              acc,
    output logic              bad
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             in_map;
    logic             ok;

    always_comb begin
        idx     = req_addr[ADDR_W-1:2];
        aligned = (req_addr[1:0] == 2'b00);
        in_map  = (idx < IDX_W'(NUM_REGS));
        ok      = aligned && in_map && (req_size == SIZE_WORD);

        acc.valid = req_valid && ok;
        acc.write = req_write;
        acc.id    = reg_id_e'(idx[ID_W-1:0]);
        acc.wdata = req_wdata;
        bad       = req_valid && !ok;
    end
endmodule

// File: rtl/mmu_reg_store.sv
module mmu_reg_store
    import mmu_regs_pkg::*;
#(
    parameter int INVAL_BIT = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  acc_t                          acc,
    output logic [NUM_REGS-1:0][DW-1:0]   regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam reg_id_e    MY_ID   = reg_id_e'(g);
        localparam logic [DW-1:0] MY_KEEP = keep_mask(MY_ID, INVAL_BIT);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (acc.valid && acc.write && acc.id == MY_ID) begin
                regs[g] <= acc.wdata & MY_KEEP;
            end
        end
    end
endmodule

// File: rtl/mmu_side_fx.sv
module mmu_side_fx
    import mmu_regs_pkg::*;
#(
    parameter int INVAL_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              inval_q,
    output logic              flush_q
);
    logic wr_ctrl;
    logic wr_pteh;

    always_comb begin
        wr_ctrl = acc.valid && acc.write && (acc.id == RID_CTRL);
        wr_pteh = acc.valid && acc.write && (acc.id == RID_PTEH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inval_q <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            inval_q <= wr_ctrl && acc.wdata[INVAL_BIT];
            flush_q <= wr_pteh && (acc.wdata[ASID_W-1:0] != cur_asid);
        end
    end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_regs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int INVAL_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic              tlb_inval,
    output logic              asid_flush
);
    acc_t                        acc;
    logic                        bad;
    logic [NUM_REGS-1:0][DW-1:0] regs;

    mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .acc       (acc),
        .bad       (bad)
    );

    mmu_reg_store #(.INVAL_BIT(INVAL_BIT)) u_store (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .regs (regs)
    );

    mmu_side_fx #(.INVAL_BIT(INVAL_BIT)) u_fx (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .cur_asid (regs[RID_PTEH][ASID_W-1:0]),
        .inval_q  (tlb_inval),
        .flush_q  (asid_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= bad;
            rsp_rdata <= (acc.valid && !acc.write) ? regs[acc.id] : '0;
        end
    end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk
    import mmu_regs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int INVAL_BIT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DW-1:0]     req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DW-1:0]     rsp_rdata,
    input logic              tlb_inval,
    input logic              asid_flush
);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_PTEH = ADDR_W'(4);

    // R4: an invalidate strobe needs a valid control write with the bit set
    p_inval_cause_r4: assert property (@(posedge clk) disable iff (rst)
        tlb_inval |-> $past(req_valid && req_write && req_size == SIZE_WORD &&
                            req_addr == OFF_CTRL && req_wdata[INVAL_BIT]));

    // R6: a flush strobe needs a valid entry-high write
    p_flush_cause_r6: assert property (@(posedge clk) disable iff (rst)
        asid_flush |-> $past(req_valid && req_write && req_size == SIZE_WORD &&
                             req_addr == OFF_PTEH));

    // R10: every request answered next cycle, and only requests
    p_rsp_next_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_source_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R2: wrong size is rejected
    p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != SIZE_WORD) |=> rsp_err);

    // R3: misaligned offset is rejected
    p_misalign_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

    // R2 and R3: an error response is quiet
    p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (!tlb_inval && !asid_flush && rsp_rdata == '0));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.ADDR_W(ADDR_W), .INVAL_BIT(INVAL_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .tlb_inval  (tlb_inval),
    .asid_flush (asid_flush)
);

// File: tb/sim_mmu_ctl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr  = '0;
    logic [1:0]  req_size  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, tlb_inval, asid_flush;
    logic [31:0] rsp_rdata;

    always #2.5 clk = ~clk;

    mmu_ctl_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .tlb_inval(tlb_inval), .asid_flush(asid_flush)
    );

    typedef struct {
        logic        err;
        logic [31:0] data;
        logic        inv;
        logic        fl;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl [9];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          mon_on  = 1'b0;

    function automatic logic [31:0] keep(int idx);
        case (idx)
            0:       return 32'hFFFF_FFFB;
            3:       return 32'h0000_000F;
            6, 7, 8: return 32'h0000_07FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic acc(input logic we, input logic [5:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        exp_t e;
        int   idx;
        bit   ok;
        idx = int'(a[5:2]);
        ok  = (sz == 2'd2) && (a[1:0] == 2'b00) && (idx < 9);
        e.tag = tag; e.err = 1'b0; e.data = '0; e.inv = 1'b0; e.fl = 1'b0;
        if (!ok) begin
            e.err = 1'b1;
        end else if (we) begin
            e.inv = (idx == 0) && wd[2];
            e.fl  = (idx == 1) && (wd[7:0] != mdl[1][7:0]);
            mdl[idx] = wd & keep(idx);
        end else begin
            e.data = mdl[idx];
        end
        req_valid = 1'b1; req_write = we; req_addr = a; req_size = sz; req_wdata = wd;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 9; i++) acc(1'b0, 6'(i * 4), 2'd2, 32'h0, tag);
    endtask

    // Monitor: compare each response cycle with the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (sb.size() != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    n_tests++;
                    if (!rsp_valid || rsp_err !== e.err || rsp_rdata !== e.data ||
                        tlb_inval !== e.inv || asid_flush !== e.fl) begin
                        n_fail++;
                        $display("FAIL %s: got v=%0b err=%0b data=%08h inv=%0b fl=%0b, expected v=1 err=%0b data=%08h inv=%0b fl=%0b",
                                 e.tag, rsp_valid, rsp_err, rsp_rdata, tlb_inval, asid_flush,
                                 e.err, e.data, e.inv, e.fl);
                    end
                end else begin
                    n_tests++;
                    if (rsp_valid !== 1'b0 || tlb_inval !== 1'b0 || asid_flush !== 1'b0) begin
                        n_fail++;
                        $display("FAIL R10 idle: got v=%0b inv=%0b fl=%0b, expected 0 0 0",
                                 rsp_valid, tlb_inval, asid_flush);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 9; i++) mdl[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_all("R1 reset value");

        // R4: invalidate bit set, bit reads back cleared
        acc(1'b1, 6'h00, 2'd2, 32'hFFFF_FFFF, "R4 ctrl write with invalidate");
        acc(1'b0, 6'h00, 2'd2, 32'h0, "R4 ctrl readback bit cleared");
        // R5: invalidate bit clear
        acc(1'b1, 6'h00, 2'd2, 32'h0000_0013, "R5 ctrl write no invalidate");
        acc(1'b0, 6'h00, 2'd2, 32'h0, "R5 ctrl readback");
        // R4 back-to-back strobes
        acc(1'b1, 6'h00, 2'd2, 32'h0000_0004, "R4 back-to-back first");
        acc(1'b1, 6'h00, 2'd2, 32'hA5A5_A5A5, "R4 back-to-back second");

        // R6: identifier change and no change
        acc(1'b1, 6'h04, 2'd2, 32'h1234_5678, "R6 new asid flush");
        acc(1'b0, 6'h04, 2'd2, 32'h0, "R6 pteh readback");
        acc(1'b1, 6'h04, 2'd2, 32'hABCD_0078, "R6 same asid no flush");
        acc(1'b0, 6'h04, 2'd2, 32'h0, "R6 full word stored");
        acc(1'b1, 6'h04, 2'd2, 32'hABCD_0079, "R6 lsb asid change flush");
        acc(1'b1, 6'h04, 2'd2, 32'h0000_0079, "R6 upper change only no flush");

        // R7: assist mask
        acc(1'b1, 6'h0C, 2'd2, 32'hFFFF_FFFF, "R7 assist write ones");
        acc(1'b0, 6'h0C, 2'd2, 32'h0, "R7 assist readback");
        acc(1'b1, 6'h0C, 2'd2, 32'h0000_00A6, "R7 assist sparse");
        acc(1'b0, 6'h0C, 2'd2, 32'h0, "R7 assist sparse readback");

        // R8: event-code masks
        acc(1'b1, 6'h18, 2'd2, 32'hFFFF_FFFF, "R8 trap write");
        acc(1'b1, 6'h1C, 2'd2, 32'h1234_5A5A, "R8 exc write");
        acc(1'b1, 6'h20, 2'd2, 32'hCAFE_0C01, "R8 int write");
        acc(1'b0, 6'h18, 2'd2, 32'h0, "R8 trap readback");
        acc(1'b0, 6'h1C, 2'd2, 32'h0, "R8 exc readback");
        acc(1'b0, 6'h20, 2'd2, 32'h0, "R8 int readback");

        // R9: full-width registers
        acc(1'b1, 6'h08, 2'd2, 32'hDEAD_BEEF, "R9 ptel write");
        acc(1'b1, 6'h10, 2'd2, 32'h8000_0001, "R9 tbase write");
        acc(1'b1, 6'h14, 2'd2, 32'h5555_AAAA, "R9 fault write");
        acc(1'b0, 6'h08, 2'd2, 32'h0, "R9 ptel readback");
        acc(1'b0, 6'h10, 2'd2, 32'h0, "R9 tbase readback");
        acc(1'b0, 6'h14, 2'd2, 32'h0, "R9 fault readback");

        // R2: wrong sizes with strobe-worthy data
        acc(1'b1, 6'h00, 2'd1, 32'hFFFF_FFFF, "R2 ctrl half-word write");
        acc(1'b1, 6'h04, 2'd0, 32'h0000_00EE, "R2 pteh byte write");
        acc(1'b0, 6'h10, 2'd3, 32'h0, "R2 read bad size");
        acc(1'b1, 6'h14, 2'd1, 32'h0, "R2 fault half-word write");

        // R3: misaligned and unmapped
        acc(1'b1, 6'h06, 2'd2, 32'h0000_00EE, "R3 misaligned write");
        acc(1'b1, 6'h02, 2'd2, 32'hFFFF_FFFF, "R3 misaligned ctrl write");
        acc(1'b1, 6'h24, 2'd2, 32'hFFFF_FFFF, "R3 unmapped write");
        acc(1'b0, 6'h3C, 2'd2, 32'h0, "R3 unmapped read");
        rd_all("R3 state unchanged after errors");

        // R10: read right after write
        acc(1'b1, 6'h10, 2'd2, 32'h0BAD_F00D, "R10 write");
        acc(1'b0, 6'h10, 2'd2, 32'h0, "R10 read immediately after write");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule